// File: doc/BRIEF.md
# ROM Fetch-Address Patch Unit

This unit sits next to a processor's instruction fetch path and lets firmware redirect execution away from faulty code in mask ROM. Software loads up to two 16-bit patch addresses and enables the matching channels. When a qualified fetch presents one of those addresses, the unit raises a branch request in that same cycle. The processor core turns the request into a jump to its patch handler. The unit also records the event in a sticky status flag for that channel.

All configuration goes through a small register bus. The bus has a byte window of five registers starting at `BASE_ADDR`:

| Offset | Contents |
|--------|----------|
| +0 | Channel 0 address, low byte |
| +1 | Channel 0 address, high byte |
| +2 | Channel 1 address, low byte |
| +3 | Channel 1 address, high byte |
| +4 | Packed control byte |

A write replaces either the whole addressed byte or only a single bit of it. Reads return data combinationally.

The fetch side is a valid-only stream with no back-pressure:
- `fetch_valid` qualifies `fetch_addr`.
- The unit accepts every beat, so no ready signal exists.
- The branch result refers to the beat on the same cycle.

Top module: `rom_patch_unit`

## Requirements
- R1: After reset, every register reads 00H: the control byte and all four address bytes. Both channels are therefore disabled with clear status.
- R2: The control byte maps as follows: bit 0 is channel 0 status, bit 1 is channel 0 enable, bit 2 is channel 1 status, and bit 3 is channel 1 enable. Bits 7..4 always read 0, whatever is written to them.
- R3: Each channel address is a 16-bit register. It is written and read as a low byte at the lower offset and a high byte at the next offset.
- R4: `branch_req` is 1 in exactly the cycles where `fetch_valid` is 1 and `fetch_addr` equals the address of an enabled channel. In those cycles, `branch_chan` gives the channel number.
- R5: A channel whose enable bit is 0 never causes a request and never sets its status, even when its address matches.
- R6: An enabled match sets that channel's status bit from the next cycle on. The bit then stays 1 while the enable stays 1.
- R7: Status bits 0 and 2 cannot be changed by any write, whether byte-wise or bit-wise.
- R8: A bit write (`bus_bit`=1) replaces only bit `bus_bitpos` of the addressed register with `bus_wdata[0]`. All other bits keep their value.
- R9: A write that puts 0 into a channel's enable bit also clears that channel's status bit. This holds for both byte writes and bit writes.
- R10: When both enabled channels match in the same cycle, `branch_chan` is 0 and both status bits become set.
- R11: A fetch address presented with `fetch_valid`=0 causes no request and leaves both status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Marks `fetch_addr` as a real instruction fetch |
| fetch_addr | input | 16 | Instruction fetch address |
| bus_addr | input | 16 | Register bus address |
| bus_we | input | 1 | Write strobe, applied at the clock edge |
| bus_bit | input | 1 | 1 selects a single-bit write, 0 a byte write |
| bus_bitpos | input | 3 | Bit position used for a single-bit write |
| bus_wdata | input | 8 | Write byte; bit 0 is the value in bit mode |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| branch_req | output | 1 | Patch branch request for the current fetch |
| branch_chan | output | 1 | Channel responsible for the request |

## Verification
The bench targets the interplay of the packed control byte with the comparators:
- **Writes that hit status positions.** The bench writes all ones and does bit writes to bits 0 and 2. A design that let these through would show status set with no fetch.
- **Writes to bits 7..4.** A bit write to bit 5 checks the upper nibble. A design with writable upper bits would read back a nonzero nibble.
- **Disabling a channel.** Clearing an enable must clear its status, so a stuck flag would read back 1.
- **Disabled and unqualified fetches.** A matching address with the channel disabled, or with `fetch_valid` low, must raise no request. A design that ignored the gate would pulse `branch_req`.
- **Both channels on one address.** A wrong priority encoder would report channel 1.
- **Bit writes to an address byte.** These catch a merge that disturbs neighbouring bits.

// File: rtl/rpatch_pkg.sv
package rpatch_pkg;
  // byte width of the register bus
  localparam int DW  = 8;
  // number of patch channels (control byte layout fixes this at two)
  localparam int NCH = 2;

  typedef logic [DW-1:0] byte_t;

  // position of a channel's status flag inside the control byte
  function automatic int stat_pos(input int ch);
    return 2 * ch;
  endfunction

  // position of a channel's enable flag inside the control byte
  function automatic int en_pos(input int ch);
    return 2 * ch + 1;
  endfunction
endpackage

// File: rtl/rpatch_bus.sv
module rpatch_bus
  import rpatch_pkg::*;
#(
  parameter int                 BUS_AW    = 16,
  parameter int                 ADDR_W    = 16,
  parameter logic [BUS_AW-1:0]  BASE_ADDR = 16'hFF80,
  localparam int                NBYTE     = ADDR_W / DW,
  localparam int                NREG      = NCH * NBYTE + 1
) (
  input  logic [BUS_AW-1:0]      bus_addr,
  input  logic                   bus_we,
  input  logic                   bus_bit,
  input  logic [2:0]             bus_bitpos,
  input  byte_t                  bus_wdata,
  input  logic [NCH*ADDR_W-1:0]  chan_addr,
  input  byte_t                  csr_val,
  output logic [NCH*NBYTE-1:0]   chan_byte_we,
  output logic                   csr_we,
  output byte_t                  wbyte,
  output byte_t                  rdata
);
  logic [NREG-1:0] reg_sel;
  byte_t           reg_byte [NREG];

  // one decoder per register address
  for (genvar r = 0; r < NREG; r++) begin : g_dec
    localparam logic [BUS_AW-1:0] RADDR = BUS_AW'(BASE_ADDR + r);
    assign reg_sel[r] = (bus_addr == RADDR);
  end

  // gather readable bytes: channel address bytes then the control byte
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar b = 0; b < NBYTE; b++) begin : g_by
      assign reg_byte[c*NBYTE+b] = chan_addr[c*ADDR_W + b*DW +: DW];
    end
  end
  assign reg_byte[NREG-1] = csr_val;

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NREG; r++) begin
      if (reg_sel[r]) rdata = reg_byte[r];
    end
  end

  // a bit write becomes a byte write of the merged current value
  always_comb begin
    wbyte = bus_wdata;
    if (bus_bit) begin
      wbyte             = rdata;
      wbyte[bus_bitpos] = bus_wdata[0];
    end
  end

  assign chan_byte_we = reg_sel[NREG-2:0] & {(NREG-1){bus_we}};
  assign csr_we       = reg_sel[NREG-1] & bus_we;
endmodule

// File: rtl/rpatch_chan.sv
module rpatch_chan
  import rpatch_pkg::*;
#(
  parameter int  ADDR_W = 16,
  localparam int NBYTE  = ADDR_W / DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTE-1:0]  byte_we,
  input  byte_t             wbyte,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] addr_q,
  output logic              hit
);
  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          addr_q[b*DW +: DW] <= '0;
      else if (byte_we[b]) addr_q[b*DW +: DW] <= wbyte;
    end
  end

  // raw comparator, only for qualified fetch beats
  assign hit = fetch_valid && (fetch_addr == addr_q);
endmodule

// File: rtl/rpatch_csr.sv
module rpatch_csr
  import rpatch_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           csr_we,
  input  byte_t          wbyte,
  input  logic [NCH-1:0] hit,
  output logic [NCH-1:0] req,
  output byte_t          csr_val
);
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] st_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int EP = en_pos(c);
    localparam int SP = stat_pos(c);

    assign req[c] = hit[c] & en_q[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[c] <= 1'b0;
        st_q[c] <= 1'b0;
      end else begin
        if (csr_we) en_q[c] <= wbyte[EP];
        if (csr_we && !wbyte[EP]) st_q[c] <= 1'b0;
        else if (req[c])          st_q[c] <= 1'b1;
      end
    end

    // R6
    stat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q[c]) |-> $past(hit[c] && en_q[c]));

    // R9
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_q[c]) |-> !st_q[c]);

    // R7
    stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && wbyte[EP] && !hit[c]) |=> (st_q[c] == $past(st_q[c])));

    // R5
    stat_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[c] && !(csr_we && wbyte[EP])) |=> !st_q[c]);
  end

  always_comb begin
    csr_val = '0;
    for (int c = 0; c < NCH; c++) begin
      csr_val[stat_pos(c)] = st_q[c];
      csr_val[en_pos(c)]   = en_q[c];
    end
  end
endmodule

// File: rtl/rom_patch_unit.sv
module rom_patch_unit
  import rpatch_pkg::*;
#(
  parameter int                BUS_AW    = 16,
  parameter int                ADDR_W    = 16,
  parameter logic [BUS_AW-1:0] BASE_ADDR = 16'hFF80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_bit,
  input  logic [2:0]        bus_bitpos,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              branch_req,
  output logic              branch_chan
);
  localparam int NBYTE = ADDR_W / DW;

  logic [NCH*ADDR_W-1:0] chan_addr;
  logic [NCH*NBYTE-1:0]  chan_byte_we;
  logic [NCH-1:0]        hit;
  logic [NCH-1:0]        req;
  logic                  csr_we;
  byte_t                 wbyte;
  byte_t                 csr_val;

  rpatch_bus #(.BUS_AW(BUS_AW), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_bus (
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_bit     (bus_bit),
    .bus_bitpos  (bus_bitpos),
    .bus_wdata   (bus_wdata),
    .chan_addr   (chan_addr),
    .csr_val     (csr_val),
    .chan_byte_we(chan_byte_we),
    .csr_we      (csr_we),
    .wbyte       (wbyte),
    .rdata       (bus_rdata)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    rpatch_chan #(.ADDR_W(ADDR_W)) i_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_we    (chan_byte_we[c*NBYTE +: NBYTE]),
      .wbyte      (wbyte),
      .fetch_valid(fetch_valid),
      .fetch_addr (fetch_addr),
      .addr_q     (chan_addr[c*ADDR_W +: ADDR_W]),
      .hit        (hit[c])
    );
  end

  rpatch_csr i_csr (
    .clk    (clk),
    .rst_n  (rst_n),
    .csr_we (csr_we),
    .wbyte  (wbyte),
    .hit    (hit),
    .req    (req),
    .csr_val(csr_val)
  );

  // lowest channel number wins
  always_comb begin
    branch_chan = 1'b0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (req[c]) branch_chan = c[0];
    end
  end
  assign branch_req = |req;

  // R4
  req_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    branch_req |-> fetch_valid);

  // R4
  req_addr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_req && !branch_chan) |-> (fetch_addr == chan_addr[ADDR_W-1:0]));

  // R10
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_req && branch_chan) |-> !(fetch_addr == chan_addr[ADDR_W-1:0] && csr_val[en_pos(0)]));
endmodule

// File: tb/test_rom_patch_unit.sv
module test_rom_patch_unit;
  localparam logic [15:0] A0L = 16'hFF80, A0H = 16'hFF81;
  localparam logic [15:0] A1L = 16'hFF82, A1H = 16'hFF83, CSR = 16'hFF84;
  localparam int P_NONE = 0, P_RD = 1, P_FE = 2;

  typedef struct {
    int         kind;
    logic [7:0] val;
    string      tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 1'b0, bus_bit = 1'b0;
  logic [2:0]  bus_bitpos = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        branch_req, branch_chan;

  int    probe = P_NONE;
  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  item_t q[$];

  always #2 clk = ~clk;

  rom_patch_unit i_rom_patch_unit (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_bit(bus_bit), .bus_bitpos(bus_bitpos),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .branch_req(branch_req), .branch_chan(branch_chan)
  );

  task automatic step();
    @(posedge clk); #1;
    bus_we = 1'b0; bus_bit = 1'b0; fetch_valid = 1'b0; probe = P_NONE;
  endtask

  task automatic idle();
    step();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    step(); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
  endtask

  task automatic bwr(input logic [15:0] a, input logic [2:0] pos, input logic v);
    step(); bus_addr = a; bus_bitpos = pos; bus_wdata = {7'b0, v};
    bus_bit = 1'b1; bus_we = 1'b1;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    step(); bus_addr = a;
    it.kind = P_RD; it.val = exp; it.tag = tag; q.push_back(it);
    probe = P_RD;
  endtask

  task automatic fetch(input logic [15:0] a, input logic v, input logic ereq,
                       input logic ech, input string tag);
    item_t it;
    step(); fetch_addr = a; fetch_valid = v;
    it.kind = P_FE; it.val = {6'b0, ereq, ech}; it.tag = tag; q.push_back(it);
    probe = P_FE;
  endtask

  // monitor: compares results against the scoreboard queue
  initial forever begin
    @(negedge clk);
    if (probe != P_NONE && q.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it  = q.pop_front();
      got = (it.kind == P_RD) ? bus_rdata : {6'b0, branch_req, branch_chan};
      n_chk++;
      if (got !== it.val) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(CSR, 8'h00, "R1 control byte after reset");
    rd(A0L, 8'h00, "R1 ch0 low after reset");
    rd(A1H, 8'h00, "R1 ch1 high after reset");
    wr(A0L, 8'h34); wr(A0H, 8'h12); wr(A1L, 8'hCD); wr(A1H, 8'hAB);
    rd(A0L, 8'h34, "R3 ch0 low");
    rd(A0H, 8'h12, "R3 ch0 high");
    rd(A1L, 8'hCD, "R3 ch1 low");
    rd(A1H, 8'hAB, "R3 ch1 high");
    fetch(16'h1234, 1'b1, 1'b0, 1'b0, "R5 disabled match no request");
    rd(CSR, 8'h00, "R5 disabled match no status");
    wr(CSR, 8'hFF);
    rd(CSR, 8'h0A, "R2 R7 all-ones write keeps status and upper zero");
    fetch(16'h1234, 1'b0, 1'b0, 1'b0, "R11 unqualified fetch no request");
    rd(CSR, 8'h0A, "R11 unqualified fetch no status");
    fetch(16'h1235, 1'b1, 1'b0, 1'b0, "R4 mismatch no request");
    fetch(16'h1234, 1'b1, 1'b1, 1'b0, "R4 ch0 request");
    rd(CSR, 8'h0B, "R6 ch0 status set");
    idle(); idle(); idle();
    rd(CSR, 8'h0B, "R6 ch0 status sticky");
    fetch(16'hABCD, 1'b1, 1'b1, 1'b1, "R4 ch1 request");
    rd(CSR, 8'h0F, "R6 ch1 status set");
    bwr(CSR, 3'd2, 1'b0);
    rd(CSR, 8'h0F, "R7 bit write to ch1 status ignored");
    bwr(CSR, 3'd0, 1'b0);
    rd(CSR, 8'h0F, "R7 bit write to ch0 status ignored");
    bwr(CSR, 3'd1, 1'b0);
    rd(CSR, 8'h0C, "R8 R9 bit clear of ch0 enable");
    fetch(16'h1234, 1'b1, 1'b0, 1'b0, "R5 ch0 disabled again");
    rd(CSR, 8'h0C, "R5 no ch0 status while disabled");
    wr(CSR, 8'h02);
    rd(CSR, 8'h02, "R9 byte write clears ch1 enable and status");
    wr(A1L, 8'h34); wr(A1H, 8'h12); wr(CSR, 8'h0A);
    fetch(16'h1234, 1'b1, 1'b1, 1'b0, "R10 both match ch0 wins");
    rd(CSR, 8'h0F, "R10 both statuses set");
    bwr(CSR, 3'd5, 1'b1);
    rd(CSR, 8'h0F, "R2 upper bit stays zero");
    bwr(A0L, 3'd0, 1'b1);
    rd(A0L, 8'h35, "R8 bit write to address byte");
    rd(A0H, 8'h12, "R8 neighbour byte untouched");
    bwr(A0H, 3'd7, 1'b1);
    rd(A0H, 8'h92, "R8 bit 7 of high byte");
    fetch(16'h9235, 1'b1, 1'b1, 1'b0, "R3 R4 ch0 request at patched address");
    idle(); idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule